// File: doc/BRIEF.md
# Adaptive Partial-Matrix LDPC Decoder

This block decodes one codeword of a small regular quasi-cyclic LDPC code. It uses layered min-sum and can run with only part of the parity-check matrix. The matrix has `J` block-rows and `K` block-columns. Each block is a `P`-by-`P` circulant. The block in block-row `i` and block-column `c` is the identity matrix rotated by `i*c` positions. For a chosen row count `x`, only the first `x` block-rows take part in message passing. Every variable node therefore keeps at least two check connections. Convergence is still judged against all `J` block-rows.

A decode begins with a start pulse. With it come the channel soft values for the whole codeword and a suggested starting row count, which the caller chooses from its own view of channel quality. If an attempt uses up its iteration budget, the block restores the original channel values, clears all check-to-variable messages and tries again with one more block-row. This continues until the full matrix has been tried. When the decode finishes, the block reports:
- the hard-decision word,
- a pass/fail flag,
- the row count that was in force,
- the iteration count.

Variable `n = c*P + t` sits in block-column `c` at offset `t`. Check `t` of block-row `i` reads the variable at offset `(t + i*c) mod P` in each block-column `c`. The block expects its reset to be released in step with `clk_i`.

Top module: `pld_decoder`

## Requirements
- R1: While reset is held and after its release, before any decode, `done_o`, `ok_o`, `codeword_o`, `rows_o` and `iters_o` are all zero.
- R2: Channel value `n` sits in bits `[4n+3:4n]` of `ch_llr_i` as a 4-bit two's-complement number. A positive soft value means bit 0. `codeword_o[n]` is 1 exactly when the final soft value of variable `n` is negative.
- R3: Before each iteration, parity is checked over all `J*P` checks. If every check is satisfied, the decode ends with `ok_o=1` and `iters_o` equal to the number of completed iterations. This count is 0 when the channel word is already valid.
- R4: The starting row count is `x_init_i`, raised to 2 if below 2 and lowered to `J` if above `J`.
- R5: An iteration visits only the `x*P` checks of the first `x` block-rows, one check per cycle, plus one parity-check cycle. A first-attempt success after `n` iterations raises `done_o` `2 + n*(x*P+1)` cycles after the edge that accepts start.
- R6: After `MAX_ITER` iterations without success, an attempt with `x < J` is abandoned. The next attempt uses `x+1`, restarts from the latched channel values and has all check-to-variable messages cleared.
- R7: Failure is reported only after an attempt with `x = J` runs out. It is reported as `ok_o=0`, `rows_o=J` and `iters_o=MAX_ITER`, with `codeword_o` holding the last hard decisions.
- R8: For each variable, a check sends back the smallest magnitude among its other inputs. The sign is the product of their signs, with zero counted as positive. All sums saturate to ±127.
- R9: `done_o` is high for exactly one cycle. The result outputs then hold until the next accepted start.
- R10: A start pulse that arrives while a decode is in progress is ignored. Its channel values and row count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a decode when the block is idle |
| ch_llr_i | input | K*P*CH_W | Channel soft values, 4 bits per variable |
| x_init_i | input | clog2(J+1)+1 | Requested starting block-row count |
| done_o | output | 1 | One-cycle end-of-decode pulse |
| ok_o | output | 1 | All full-matrix checks satisfied |
| codeword_o | output | K*P | Hard decisions |
| rows_o | output | clog2(J+1)+1 | Block-row count of the final attempt |
| iters_o | output | clog2(MAX_ITER+1) | Iterations of the final attempt |

## Verification
A wrong sweep bound, a bad circulant offset or a lost retry step changes when the decode ends. The end-of-decode pulse moves by a whole number of check cycles, or by an entire attempt, within the same decode. A min-sum sign or magnitude error leaves a single flipped bit uncorrected after the first layer. The decode then runs out of iterations instead of ending after one pass, which shows up in the pass flag, the reported counts and the timing of the end pulse. A failure of a stuck word to report the full matrix and the iteration cap shows up on the last pulse.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SYN,
    ST_CN
  } pld_state_e;
endpackage

// File: rtl/pld_syndrome.sv
// Full-matrix parity evaluation of the current hard decisions.
module pld_syndrome #(
  parameter int P = 5,
  parameter int J = 3,
  parameter int K = 5
) (
  input  logic [K*P-1:0] hard_i,
  output logic           zero_o
);
  localparam int M = J * P;

  logic [M-1:0] syn;

  for (genvar gi = 0; gi < J; gi++) begin : g_brow
    for (genvar gr = 0; gr < P; gr++) begin : g_chk
      logic acc;
      always_comb begin
        acc = 1'b0;
        for (int c = 0; c < K; c++) begin
          acc = acc ^ hard_i[c*P + ((gr + gi*c) % P)];
        end
      end
      assign syn[gi*P + gr] = acc;
    end
  end

  assign zero_o = ~|syn;
endmodule

// File: rtl/pld_cnu.sv
// Min-sum check-node unit: two's complement in, sign-magnitude search, two's complement out.
module pld_cnu #(
  parameter int K = 5,
  parameter int W = 8
) (
  input  logic [K*W-1:0] v2c_i,
  output logic [K*W-1:0] c2v_o
);
  localparam int IW = $clog2(K);
  localparam logic [W-1:0] MAXMAG = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0]  mag [K];
  logic [K-1:0]  sgn;
  logic [W-1:0]  min1, min2, om;
  logic [IW-1:0] idx;
  logic          par, os;

  always_comb begin
    par  = 1'b0;
    min1 = MAXMAG;
    min2 = MAXMAG;
    idx  = '0;
    for (int c = 0; c < K; c++) begin
      sgn[c] = v2c_i[c*W + W-1];
      mag[c] = sgn[c] ? -v2c_i[c*W +: W] : v2c_i[c*W +: W];
      if (mag[c] > MAXMAG) mag[c] = MAXMAG;
      par = par ^ sgn[c];
      if (mag[c] < min1) begin
        min2 = min1;
        min1 = mag[c];
        idx  = IW'(c);
      end else if (mag[c] < min2) begin
        min2 = mag[c];
      end
    end
    om = '0;
    os = 1'b0;
    for (int c = 0; c < K; c++) begin
      om = (IW'(c) == idx) ? min2 : min1;
      os = par ^ sgn[c];
      c2v_o[c*W +: W] = os ? -om : om;
    end
  end
endmodule

// File: rtl/pld_decoder.sv
// Layered min-sum decoder over a growing prefix of block-rows.
module pld_decoder
  import pld_pkg::*;
#(
  parameter int P        = 5,
  parameter int J        = 3,
  parameter int K        = 5,
  parameter int MAX_ITER = 30,
  parameter int CH_W     = 4,
  parameter int MSG_W    = 8,
  localparam int N  = K * P,
  localparam int XW = $clog2(J + 1) + 1,
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N*CH_W-1:0] ch_llr_i,
  input  logic [XW-1:0]   x_init_i,
  output logic            done_o,
  output logic            ok_o,
  output logic [N-1:0]    codeword_o,
  output logic [XW-1:0]   rows_o,
  output logic [IW-1:0]   iters_o
);
  localparam int M  = J * P;
  localparam int NW = $clog2(N);
  localparam int BW = (J > 1) ? $clog2(J) : 1;
  localparam int PW = (P > 1) ? $clog2(P) : 1;
  localparam logic signed [MSG_W:0] HI = (MSG_W+1)'(2**(MSG_W-1) - 1);
  localparam logic signed [MSG_W:0] LO = -HI;

  function automatic logic signed [MSG_W-1:0] sat_add(
    input logic signed [MSG_W-1:0] a,
    input logic signed [MSG_W-1:0] b
  );
    logic signed [MSG_W:0] s;
    s = {a[MSG_W-1], a} + {b[MSG_W-1], b};
    if (s > HI) return HI[MSG_W-1:0];
    if (s < LO) return LO[MSG_W-1:0];
    return s[MSG_W-1:0];
  endfunction

  pld_state_e state_q, state_d;
  logic [N*CH_W-1:0] ch_q, ch_d;
  logic [XW-1:0]     x_q, x_d, x_start;
  logic [BW-1:0]     brow_q, brow_d;
  logic [PW-1:0]     pos_q, pos_d;
  logic [IW-1:0]     iter_q, iter_d;
  logic signed [MSG_W-1:0] llr_q [N];
  logic signed [MSG_W-1:0] llr_d [N];
  logic signed [MSG_W-1:0] c2v_q [M][K];
  logic signed [MSG_W-1:0] c2v_d [M][K];
  logic              done_q, done_d, ok_q, ok_d;
  logic [N-1:0]      cw_q, cw_d, hard;
  logic [XW-1:0]     rows_q, rows_d;
  logic [IW-1:0]     iters_q, iters_d;
  logic              ch_en, msg_en, res_en, syn_zero;

  // Hard decisions and full-matrix parity
  always_comb begin
    for (int n = 0; n < N; n++) hard[n] = llr_q[n][MSG_W-1];
  end

  pld_syndrome #(.P(P), .J(J), .K(K)) syn_i (
    .hard_i (hard),
    .zero_o (syn_zero)
  );

  // Check-node datapath for the check addressed by (brow_q, pos_q)
  int                 chk;
  logic [NW-1:0]      vidx [K];
  logic [K*MSG_W-1:0] v2c_vec, c2v_new;

  always_comb begin
    chk = int'(brow_q) * P + int'(pos_q);
    for (int c = 0; c < K; c++) begin
      vidx[c] = NW'(c*P + ((int'(pos_q) + int'(brow_q)*c) % P));
      v2c_vec[c*MSG_W +: MSG_W] = sat_add(llr_q[vidx[c]], -c2v_q[chk][c]);
    end
  end

  pld_cnu #(.K(K), .W(MSG_W)) cnu_i (
    .v2c_i (v2c_vec),
    .c2v_o (c2v_new)
  );

  always_comb begin
    if (x_init_i < XW'(2))      x_start = XW'(2);
    else if (x_init_i > XW'(J)) x_start = XW'(J);
    else                        x_start = x_init_i;
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    x_d     = x_q;
    brow_d  = brow_q;
    pos_d   = pos_q;
    iter_d  = iter_q;
    llr_d   = llr_q;
    c2v_d   = c2v_q;
    done_d  = 1'b0;
    ok_d    = ok_q;
    cw_d    = cw_q;
    rows_d  = rows_q;
    iters_d = iters_q;
    ch_en   = 1'b0;
    msg_en  = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ch_en   = 1'b1;
          ch_d    = ch_llr_i;
          x_d     = x_start;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        msg_en = 1'b1;
        for (int n = 0; n < N; n++) begin
          llr_d[n] = {{(MSG_W-CH_W){ch_q[n*CH_W + CH_W-1]}}, ch_q[n*CH_W +: CH_W]};
        end
        for (int m = 0; m < M; m++) begin
          for (int c = 0; c < K; c++) c2v_d[m][c] = '0;
        end
        iter_d  = '0;
        state_d = ST_SYN;
      end
      ST_SYN: begin
        if (syn_zero || (iter_q == IW'(MAX_ITER) && x_q == XW'(J))) begin
          res_en  = 1'b1;
          done_d  = 1'b1;
          ok_d    = syn_zero;
          cw_d    = hard;
          rows_d  = x_q;
          iters_d = iter_q;
          state_d = ST_IDLE;
        end else if (iter_q == IW'(MAX_ITER)) begin
          x_d     = x_q + XW'(1);
          state_d = ST_LOAD;
        end else begin
          brow_d  = '0;
          pos_d   = '0;
          state_d = ST_CN;
        end
      end
      ST_CN: begin
        msg_en = 1'b1;
        for (int c = 0; c < K; c++) begin
          c2v_d[chk][c]  = c2v_new[c*MSG_W +: MSG_W];
          llr_d[vidx[c]] = sat_add(v2c_vec[c*MSG_W +: MSG_W], c2v_new[c*MSG_W +: MSG_W]);
        end
        if (pos_q == PW'(P-1)) begin
          pos_d = '0;
          if (int'(brow_q) == int'(x_q) - 1) begin
            iter_d  = iter_q + IW'(1);
            state_d = ST_SYN;
          end else begin
            brow_d = brow_q + BW'(1);
          end
        end else begin
          pos_d = pos_q + PW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      x_q     <= '0;
      brow_q  <= '0;
      pos_q   <= '0;
      iter_q  <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      cw_q    <= '0;
      rows_q  <= '0;
      iters_q <= '0;
      for (int n = 0; n < N; n++) llr_q[n] <= '0;
      for (int m = 0; m < M; m++) begin
        for (int c = 0; c < K; c++) c2v_q[m][c] <= '0;
      end
    end else begin
      state_q <= state_d;
      x_q     <= x_d;
      brow_q  <= brow_d;
      pos_q   <= pos_d;
      iter_q  <= iter_d;
      done_q  <= done_d;
      if (ch_en) ch_q <= ch_d;
      if (msg_en) begin
        llr_q <= llr_d;
        c2v_q <= c2v_d;
      end
      if (res_en) begin
        ok_q    <= ok_d;
        cw_q    <= cw_d;
        rows_q  <= rows_d;
        iters_q <= iters_d;
      end
    end
  end

  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign codeword_o = cw_q;
  assign rows_o     = rows_q;
  assign iters_o    = iters_q;

  // Assertions
  AST_ROWS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (x_q >= XW'(2) && x_q <= XW'(J))); // R4
  AST_OK_MEANS_ZERO_SYN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> syn_zero); // R3
  AST_ITER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_q <= IW'(MAX_ITER)); // R6
  AST_FAIL_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_o) |-> (rows_o == XW'(J) && iters_o == IW'(MAX_ITER))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(ch_q)); // R10
endmodule

// File: tb/pld_decoder_tb_top.sv
module pld_decoder_tb_top;
  localparam int P = 5, J = 3, K = 5, MAXI = 30, N = K * P;

  typedef struct packed {
    logic [2:0]        x0;
    logic [4:0]        epos;
    logic signed [3:0] eval;
    logic signed [3:0] base;
    logic              ok;
    logic [2:0]        xr;
    logic [4:0]        it;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd2, 5'd0,  4'sd5,  4'sd5, 1'b1, 3'd2, 5'd0},  // R3 valid channel word
    '{3'd2, 5'd7,  -4'sd1, 4'sd7, 1'b1, 3'd2, 5'd1},  // R8 single flip
    '{3'd3, 5'd7,  -4'sd1, 4'sd7, 1'b1, 3'd3, 5'd1},  // R5 more rows
    '{3'd0, 5'd19, -4'sd1, 4'sd7, 1'b1, 3'd2, 5'd1},  // R4 raise to 2
    '{3'd7, 5'd19, -4'sd1, 4'sd7, 1'b1, 3'd3, 5'd1},  // R4 cap at J
    '{3'd1, 5'd3,  -4'sd1, 4'sd7, 1'b1, 3'd2, 5'd1},  // R4 raise to 2
    '{3'd2, 5'd12, -4'sd1, 4'sd0, 1'b0, 3'd3, 5'd30}, // R6 retry then R7
    '{3'd3, 5'd24, -4'sd1, 4'sd0, 1'b0, 3'd3, 5'd30}  // R7 full only
  };

  logic           clk, rst_n, start;
  logic [N*4-1:0] ch;
  logic [2:0]     x_init;
  logic           done, ok;
  logic [N-1:0]   cw;
  logic [2:0]     rows;
  logic [4:0]     iters;
  int checks = 0;
  int errors = 0;

  pld_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ch_llr_i(ch),
    .x_init_i(x_init), .done_o(done), .ok_o(ok), .codeword_o(cw),
    .rows_o(rows), .iters_o(iters)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int clampx(input int x);
    if (x < 2) return 2;
    if (x > J) return J;
    return x;
  endfunction

  function automatic int exp_cnt(input int x0, input bit good, input int it);
    int s;
    if (good) return 3 + it * (x0 * P + 1);
    s = 1;
    for (int x = x0; x <= J; x++) s += 2 + MAXI * (x * P + 1);
    return s;
  endfunction

  function automatic logic [N*4-1:0] make_ch(input logic [3:0] base, input int epos,
                                             input logic [3:0] ev);
    logic [N*4-1:0] v;
    for (int n = 0; n < N; n++) v[n*4 +: 4] = (n == epos) ? ev : base;
    return v;
  endfunction

  task automatic wait_done(output int cnt);
    cnt = 0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      start = 1'b0;
    end while (!done && cnt < 5000);
  endtask

  initial begin
    int cnt;
    vec_t v;
    logic [N-1:0] ecw;
    rst_n = 1'b0; start = 1'b0; ch = '0; x_init = '0;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 ok", ok, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after release", done, 0);
    chk("R1 codeword", cw, 0);
    chk("R1 rows", rows, 0);
    chk("R1 iters", iters, 0);

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      ecw = v.ok ? '0 : (N'(1) << v.epos);
      @(negedge clk);
      ch = make_ch(v.base, v.epos, v.eval);
      x_init = v.x0;
      start = 1'b1;
      wait_done(cnt);
      chk("R3/R7 ok flag", ok, v.ok);
      chk("R4/R7 rows", rows, v.xr);
      chk("R3/R6 iters", iters, v.it);
      chk("R2 codeword", cw, ecw);
      chk("R5/R6 latency", cnt, exp_cnt(clampx(int'(v.x0)), v.ok, int'(v.it)));
      @(negedge clk);
      chk("R9 done pulse", done, 0);
      chk("R9 hold", {ok, rows, iters}, {v.ok, v.xr, v.it});
    end

    // R10: a start while busy changes nothing
    @(negedge clk);
    ch = make_ch(4'sd0, 12, -4'sd1);
    x_init = 3'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    ch = make_ch(4'sd5, 0, 4'sd5);
    x_init = 3'd3;
    start = 1'b1;
    wait_done(cnt);
    chk("R10 ok", ok, 0);
    chk("R10 rows", rows, J);
    chk("R10 codeword", cw, N'(1) << 12);
    chk("R10 latency", cnt + 6, exp_cnt(2, 1'b0, MAXI));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule